// File: doc/BRIEF.md
# Per-Channel Input Mapping Gate

This block produces the gate enable for each of a set of low-side output channels. Each channel has a software switch bit. A single external input pin is shared by all channels. Per channel, a mapping bit decides whether that pin takes part at all. When it does, an operator bit decides whether the pin is ORed or ANDed with the software bit. A protection inhibit from the fault logic overrides everything and holds the channel off.

The external pin is asynchronous. It passes through a two-flop synchroniser before it is used. The per-channel slope-select bit is registered together with the gate enable, so the analog driver receives both in the same cycle. The mapping, operator, switch and slope bits come from a register block elsewhere. This block only consumes them.

Top module: `chgate_top`

## Requirements
- R1: With a channel's mapping bit at 0, its gate enable equals its software switch bit one clock after that bit is sampled, whatever the external pin does.
- R2: With the mapping bit at 1 and the operator bit at 0, the gate enable is the OR of the software bit and the synchronised pin. A high pin therefore turns the channel on just as a software ON does.
- R3: With the mapping bit at 1 and the operator bit at 1, the gate enable is the AND of the software bit and the synchronised pin.
- R4: While a channel's inhibit bit is 1, its gate enable is 0 from the next clock on, regardless of its other inputs.
- R5: Each channel's slope-select output equals its slope-select input delayed by one clock. The encoding is 0 for fast and 1 for slow.
- R6: A change on the external pin reaches a mapped channel's gate enable at the third rising edge after the pin changes, and not at the second.
- R7: While reset is high, all gate enables and slope-select outputs are 0 from the first clock on, and the synchroniser is cleared.
- R8: Channels are independent. A mixed set of mapping and operator bits gives each channel the result of its own bits only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_on_i | input | N_CH | Software switch bit per channel |
| pin_map_i | input | N_CH | 1 lets the external pin take part for that channel |
| and_sel_i | input | N_CH | Operator per channel: 0 OR, 1 AND |
| inhibit_i | input | N_CH | Protection inhibit per channel, forces the channel off |
| slow_i | input | N_CH | Slope select per channel: 0 fast, 1 slow |
| ext_pin_i | input | 1 | Shared asynchronous external control pin |
| gate_en_o | output | N_CH | Registered gate enable per channel |
| slow_o | output | N_CH | Registered slope select per channel |

## Verification
The assertions take for granted that the configuration, switch, inhibit and slope inputs are synchronous to clk. Only the external pin may change at any time. The stimulus drives every input away from the rising edge and holds each configuration for at least one full clock. It holds the pin steady for three clocks before any result that depends on the pin is compared. The only exception is the check of the pin path's latency, which samples at the second and third edges on purpose.

// File: rtl/chgate_pkg.sv
package chgate_pkg;

    typedef enum logic {
        OP_OR  = 1'b0,
        OP_AND = 1'b1
    } comb_op_e;

    typedef struct packed {
        logic     sw_on;
        logic     use_pin;
        comb_op_e op;
        logic     inhibit;
        logic     slow;
    } lane_cfg_t;

    typedef struct packed {
        logic gate;
        logic slow;
    } lane_out_t;

    function automatic logic lane_combine(input lane_cfg_t cfg, input logic pin);
        logic r;
        if (!cfg.use_pin)          r = cfg.sw_on;
        else if (cfg.op == OP_AND) r = cfg.sw_on & pin;
        else                       r = cfg.sw_on | pin;
        return r & ~cfg.inhibit;
    endfunction

endpackage

// File: rtl/chgate_sync.sv
module chgate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

    AST_SYNC_RST: assert property (@(posedge clk) rst |=> !sync_o); // R7
endmodule

// File: rtl/chgate_lane.sv
module chgate_lane
    import chgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_cfg_t cfg_i,
    input  logic      pin_i,
    output lane_out_t out_o
);
    lane_out_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.gate <= lane_combine(cfg_i, pin_i);
            out_q.slow <= cfg_i.slow;
        end
    end

    assign out_o = out_q;

    AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (rst)
        cfg_i.inhibit |=> !out_o.gate); // R4
    AST_DIRECT_CTL: assert property (@(posedge clk) disable iff (rst)
        (!cfg_i.use_pin && !cfg_i.inhibit) |=> (out_o.gate == $past(cfg_i.sw_on))); // R1
    AST_OR_FORCES_ON: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.use_pin && cfg_i.op == OP_OR && cfg_i.sw_on && !cfg_i.inhibit) |=> out_o.gate); // R2
    AST_AND_NEEDS_SW: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.use_pin && cfg_i.op == OP_AND && !cfg_i.sw_on) |=> !out_o.gate); // R3
    AST_SLEW_PASS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_o.slow == $past(cfg_i.slow))); // R5
    AST_RST_OFF: assert property (@(posedge clk)
        rst |=> (!out_o.gate && !out_o.slow)); // R7
endmodule

// File: rtl/chgate_top.sv
module chgate_top
    import chgate_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] sw_on_i,
    input  logic [N_CH-1:0] pin_map_i,
    input  logic [N_CH-1:0] and_sel_i,
    input  logic [N_CH-1:0] inhibit_i,
    input  logic [N_CH-1:0] slow_i,
    input  logic            ext_pin_i,
    output logic [N_CH-1:0] gate_en_o,
    output logic [N_CH-1:0] slow_o
);
    logic pin_sync;

    chgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_pin_i),
        .sync_o  (pin_sync)
    );

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
            lane_cfg_t cfg;
            lane_out_t res;

            always_comb begin
                cfg.sw_on   = sw_on_i[ch];
                cfg.use_pin = pin_map_i[ch];
                cfg.op      = and_sel_i[ch] ? OP_AND : OP_OR;
                cfg.inhibit = inhibit_i[ch];
                cfg.slow    = slow_i[ch];
            end

            chgate_lane u_lane (
                .clk   (clk),
                .rst   (rst),
                .cfg_i (cfg),
                .pin_i (pin_sync),
                .out_o (res)
            );

            assign gate_en_o[ch] = res.gate;
            assign slow_o[ch]    = res.slow;
        end
    endgenerate

    AST_UNMAPPED_IGNORE_PIN: assert property (@(posedge clk) disable iff (rst)
        (pin_map_i == '0 && inhibit_i == '0) |=> (gate_en_o == $past(sw_on_i))); // R8
endmodule

// File: tb/test_chgate_top.sv
module test_chgate_top;
    localparam int N = 8;

    typedef struct {
        logic [N-1:0] gate;
        logic [N-1:0] slow;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] sw_on, pin_map, and_sel, inhibit, slow_in;
    logic         ext_pin;
    logic [N-1:0] gate_en, slow_out;

    int n_tests = 0;
    int n_fail  = 0;
    exp_t sb_q[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    chgate_top #(.N_CH(N), .SYNC_STAGES(2)) i_chgate_top (
        .clk       (clk),
        .rst       (rst),
        .sw_on_i   (sw_on),
        .pin_map_i (pin_map),
        .and_sel_i (and_sel),
        .inhibit_i (inhibit),
        .slow_i    (slow_in),
        .ext_pin_i (ext_pin),
        .gate_en_o (gate_en),
        .slow_o    (slow_out)
    );

    function automatic logic [N-1:0] model(input logic [N-1:0] c, m, o, h, input logic p);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (h[i])       r[i] = 1'b0;
            else if (!m[i]) r[i] = c[i];
            else if (o[i])  r[i] = c[i] & p;
            else            r[i] = c[i] | p;
        end
        return r;
    endfunction

    task automatic push_exp(input logic [N-1:0] g, input logic [N-1:0] s, input string tag);
        exp_t e;
        e.gate = g;
        e.slow = s;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic apply(input logic [N-1:0] c, m, o, h, s, input logic p,
                         input int waits, input logic p_exp, input string tag);
        @(negedge clk);
        sw_on = c; pin_map = m; and_sel = o; inhibit = h; slow_in = s; ext_pin = p;
        repeat (waits) @(posedge clk);
        push_exp(model(c, m, o, h, p_exp), s, tag);
    endtask

    // monitor: pops expected items and compares at the following falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_tests++;
                if (gate_en !== e.gate || slow_out !== e.slow) begin
                    n_fail++;
                    $display("FAIL %s gate=%h slow=%h expected gate=%h slow=%h",
                             e.tag, gate_en, slow_out, e.gate, e.slow);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        sw_on = '1; pin_map = '1; and_sel = '0; inhibit = '0; slow_in = '1; ext_pin = 1'b1;
        repeat (3) @(posedge clk);
        push_exp('0, '0, "R7 reset holds outputs low");
        @(negedge clk);
        sw_on = '0; pin_map = '0; slow_in = '0; ext_pin = 1'b0;
        rst = 1'b0;

        // R1: unmapped channels follow the software bit, pin ignored
        apply(8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 3, 1'b1, "R1 direct pin high");
        apply(8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1, 1'b1, "R1 one-cycle latency");
        apply(8'h5A, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 3, 1'b0, "R1 direct pin low");

        // R2: OR mapping
        apply(8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 3, 1'b0, "R2 OR pin low");
        apply(8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 3, 1'b1, "R2 OR pin high acts as ON");

        // R3: AND mapping
        apply(8'h0F, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b1, 3, 1'b1, "R3 AND pin high");
        apply(8'h0F, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0, 3, 1'b0, "R3 AND pin low");

        // R8: mixed per-channel configuration
        apply(8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 1'b1, 3, 1'b1, "R8 only ch3 mapped");
        apply(8'hA0, 8'hF0, 8'hC0, 8'h00, 8'h00, 1'b1, 3, 1'b1, "R8 mixed ops");
        apply(8'h3C, 8'h99, 8'h81, 8'h00, 8'h00, 1'b0, 3, 1'b0, "R8 mixed ops pin low");

        // R4: inhibit overrides
        apply(8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b1, 1, 1'b1, "R4 full inhibit");
        apply(8'hFF, 8'h00, 8'h00, 8'h0F, 8'h00, 1'b1, 1, 1'b1, "R4 partial inhibit");

        // R5: slope select pass-through
        apply(8'h00, 8'h00, 8'h00, 8'h00, 8'h3C, 1'b1, 1, 1'b1, "R5 slope 3C");
        apply(8'h00, 8'h00, 8'h00, 8'h00, 8'hC3, 1'b1, 1, 1'b1, "R5 slope C3");

        // R6: pin latency through the synchroniser
        apply(8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 3, 1'b0, "R6 settle low");
        apply(8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 2, 1'b0, "R6 not yet at edge 2");
        @(posedge clk);
        push_exp(8'hFF, 8'h00, "R6 visible at edge 3");

        // R7: reset again with active inputs
        @(negedge clk);
        sw_on = '1; slow_in = '1; rst = 1'b1;
        @(posedge clk);
        push_exp('0, '0, "R7 reset mid-run");
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule